// File: doc/BRIEF.md
# Interrupt Source Collector with Read-Clear Status

This block gathers a set of independent interrupt event pulses into one interrupt request line. Each source has a sticky status bit that is set by an event and stays set until software reads the status. An enable state chosen per source decides which status bits may drive the request line. Software changes the enable state through two write-only strobes. One sets enable bits for every 1 in its data word. The other clears enable bits for every 1 in its data word. In both, 0 bits leave the enable state as it is. A read-only mask view shows the enable state inverted, so a 1 there means the source is disabled.

Reading the status returns the bits latched so far and clears them in the same step. An event that arrives in the cycle of the read is kept for the next read, so it is never lost. A status bit latches whether or not its source is enabled. Enabling a source whose bit is already set therefore raises the request line. The request line is a registered OR of all status bits whose source is enabled. All pins are plain control and status signals. There is no stream interface and no back-pressure.

Top module: `irq_collector`

## Requirements
- R1: After reset all status bits are 0, every source is disabled (`mask_rdata` reads all ones), `stat_rdata` is 0 and `irq` is low.
- R2: A 1 on `src_evt[i]` at a rising clock edge sets status bit i. A pulse on `stat_rd` at an edge makes `stat_rdata` show the status as it was before that edge, from the next cycle on, with bit i at position i.
- R3: A read through `stat_rd` clears every status bit that no event sets at the same edge. A second read with no events in between returns 0.
- R4: An event at the same edge as a read does not appear in that read's data. It stays set, and the next read returns it.
- R5: `set_we` with `set_bits` enables each source whose bit is 1. Sources at 0 bits keep their previous enable state.
- R6: `clr_we` with `clr_bits` disables each source whose bit is 1. Sources at 0 bits keep their previous enable state.
- R7: `mask_rdata[i]` is 1 exactly when source i is disabled. It reflects a change on the cycle after the write edge.
- R8: When `set_we` and `clr_we` both carry a 1 for the same bit at one edge, that source ends up disabled.
- R9: `irq` is registered. It goes high one edge after an enabled source's status bit becomes set. It goes low one edge after no enabled status bit remains.
- R10: Status bits latch while their source is disabled, and `irq` stays low. Enabling such a source later raises `irq` without a new event.
- R11: Status bits stay set across later cycles and across disabling, until they are read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_SRC | Event pulses, one per source |
| set_we | input | 1 | Strobe for enabling sources |
| set_bits | input | NUM_SRC | Sources to enable (1 = enable) |
| clr_we | input | 1 | Strobe for disabling sources |
| clr_bits | input | NUM_SRC | Sources to disable (1 = disable) |
| stat_rd | input | 1 | Status read strobe, clears status |
| stat_rdata | output | NUM_SRC | Status captured by the last read |
| mask_rdata | output | NUM_SRC | Disabled view, 1 = source disabled |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the pins is an event arriving in the very edge where software reads and clears the status. A correct design must leave it out of that read's data and still keep it for the next read. The bench drives `stat_rd` and a fresh `src_evt` bit together on one falling edge, so both land on the same rising edge. It then reads twice to tell apart the pre-read data and the surviving bit. The same-edge case of enable and disable strobes is reached the same way, and the result is read through `mask_rdata`.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_DEF_SRCS = 15;

  // Next enable state: set first, then clear, so a clear always dominates.
  function automatic logic [63:0] irq_next_enable(
    input logic [63:0] cur,
    input logic        set_en,
    input logic [63:0] set_v,
    input logic        clr_en,
    input logic [63:0] clr_v
  );
    logic [63:0] tmp;
    tmp = cur | (set_en ? set_v : 64'd0);
    tmp = tmp & ~(clr_en ? clr_v : 64'd0);
    return tmp;
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_DEF_SRCS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               rd,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] rdata
);
  // Per-bit sticky flops: the read clears, and an event at the same edge re-sets.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) status[g] <= 1'b0;
      else        status[g] <= (status[g] & ~rd) | evt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= status;
  end

  AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && evt == '0) |=> (status == '0)); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd) |=> ((status & $past(status)) == $past(status))); // R11
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_DEF_SRCS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we,
  input  logic [NUM_SRC-1:0] set_bits,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] en
);
  localparam int unsigned PADW = 64 - NUM_SRC;
  logic [63:0] nxt_wide;

  always_comb begin
    nxt_wide = irq_pkg::irq_next_enable({{PADW{1'b0}}, en}, set_we,
                                        {{PADW{1'b0}}, set_bits}, clr_we,
                                        {{PADW{1'b0}}, clr_bits});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en <= '0;
    else        en <= nxt_wide[NUM_SRC-1:0];
  end

  AST_CLR_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en & $past(clr_bits)) == '0)); // R8
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((en & $past(set_bits)) == $past(set_bits))); // R5
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en)); // R6
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_DEF_SRCS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] en,
  output logic               irq
);
  logic any_live;
  assign any_live = |(status & en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_live;
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq); // R10
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_DEF_SRCS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               set_we,
  input  logic [NUM_SRC-1:0] set_bits,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] clr_bits,
  input  logic               stat_rd,
  output logic [NUM_SRC-1:0] stat_rdata,
  output logic [NUM_SRC-1:0] mask_rdata,
  output logic               irq
);
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] en_q;

  irq_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .rd(stat_rd),
    .status(status_q), .rdata(stat_rdata)
  );

  irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .set_bits(set_bits),
    .clr_we(clr_we), .clr_bits(clr_bits), .en(en_q)
  );

  irq_combine #(.NUM_SRC(NUM_SRC)) u_combine (
    .clk(clk), .rst_n(rst_n), .status(status_q), .en(en_q), .irq(irq)
  );

  assign mask_rdata = ~en_q;

  AST_READ_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && src_evt == '0) ##1 (src_evt == '0) |=> !irq); // R9
  AST_MASK_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_rdata & $past(clr_bits)) == $past(clr_bits))); // R7
endmodule

// File: tb/tb_irq_collector.sv
module tb_irq_collector;
  localparam int unsigned N = 15;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic         set_we = 1'b0;
  logic [N-1:0] set_bits = '0;
  logic         clr_we = 1'b0;
  logic [N-1:0] clr_bits = '0;
  logic         stat_rd = 1'b0;
  logic [N-1:0] stat_rdata;
  logic [N-1:0] mask_rdata;
  logic         irq;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector #(.NUM_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .set_we(set_we),
    .set_bits(set_bits), .clr_we(clr_we), .clr_bits(clr_bits),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .mask_rdata(mask_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] v);
    src_evt = v; cyc(1); src_evt = '0;
  endtask

  task automatic do_read();
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
  endtask

  task automatic do_set(input logic [N-1:0] v);
    set_we = 1'b1; set_bits = v; cyc(1); set_we = 1'b0; set_bits = '0;
  endtask

  task automatic do_clr(input logic [N-1:0] v);
    clr_we = 1'b1; clr_bits = v; cyc(1); clr_we = 1'b0; clr_bits = '0;
  endtask

  task automatic clean();
    do_clr('1); do_read(); cyc(2);
  endtask

  task automatic t_reset();
    check("R1 mask", 32'(mask_rdata), 32'h7FFF);
    check("R1 rdata", 32'(stat_rdata), 0);
    check("R1 irq", 32'(irq), 0);
    do_read();
    check("R1 status", 32'(stat_rdata), 0);
  endtask

  task automatic t_capture_read();
    pulse(15'h0009); cyc(1); pulse(15'h4000);
    do_read();
    check("R2 rdata", 32'(stat_rdata), 32'h4009);
    do_read();
    check("R3 second read", 32'(stat_rdata), 0);
  endtask

  task automatic t_collision();
    pulse(15'h0004);
    src_evt = 15'h0020; stat_rd = 1'b1; cyc(1);
    src_evt = '0; stat_rd = 1'b0;
    check("R4 first read", 32'(stat_rdata), 32'h0004);
    do_read();
    check("R4 kept bit", 32'(stat_rdata), 32'h0020);
  endtask

  task automatic t_enable_disable();
    do_set(15'h0011);
    check("R5 R7 mask after set", 32'(mask_rdata), 32'h7FEE);
    do_set(15'h0100);
    check("R5 zero bits keep", 32'(mask_rdata), 32'h7EEE);
    do_clr(15'h0001);
    check("R6 clear one", 32'(mask_rdata), 32'h7EEF);
    do_clr(15'h0000);
    check("R6 zero bits keep", 32'(mask_rdata), 32'h7EEF);
  endtask

  task automatic t_same_cycle();
    do_set(15'h0008);
    check("R8 pre", 32'(mask_rdata), 32'h7FF7);
    set_we = 1'b1; set_bits = 15'h0018; clr_we = 1'b1; clr_bits = 15'h0018;
    cyc(1);
    set_we = 1'b0; clr_we = 1'b0; set_bits = '0; clr_bits = '0;
    check("R8 clr dominates", 32'(mask_rdata), 32'h7FFF);
  endtask

  task automatic t_irq_timing();
    do_set(15'h0002);
    pulse(15'h0002);
    check("R9 irq one edge later", 32'(irq), 0);
    cyc(1);
    check("R9 irq high", 32'(irq), 1);
    do_read();
    check("R9 irq lags clear", 32'(irq), 1);
    cyc(1);
    check("R9 irq low", 32'(irq), 0);
  endtask

  task automatic t_latched_disabled();
    pulse(15'h0080); cyc(2);
    check("R10 disabled no irq", 32'(irq), 0);
    do_set(15'h0080);
    check("R10 irq after en lag", 32'(irq), 0);
    cyc(1);
    check("R10 irq on late enable", 32'(irq), 1);
    do_clr(15'h0080); cyc(1);
    check("R11 irq off after disable", 32'(irq), 0);
    cyc(3);
    do_read();
    check("R11 status held", 32'(stat_rdata), 32'h0080);
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();            clean();
    t_capture_read();     clean();
    t_collision();        clean();
    t_enable_disable();   clean();
    t_same_cycle();       clean();
    t_irq_timing();       clean();
    t_latched_disabled(); clean();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule